// File: doc/BRIEF.md
# Discrete 32 KiB Program Bank Switch with Bus Conflicts

This block is the whole mapping logic of a small cartridge. The CPU sees program ROM in the top 32 KiB of its address space. Any CPU write into that half stores a small bank number. That number drives the upper ROM address lines, so one of four 32 KiB banks inside a 128 KiB ROM is selected.

The ROM has no write gating and drives the data bus during a write. For that reason the stored value is the CPU data ANDed bit by bit with the ROM byte at the written address. Software must write to a location whose ROM byte already holds the bits it wants set.

On the picture side, the 8 KiB character memory is not banked and its address passes straight through. A static strap picks horizontal or vertical nametable mirroring. The ROM array itself lives outside the block. The ROM byte at the current address comes back on an input, and the block uses it in the same cycle as the write.

Top module: `prg_bank_switch`

## Requirements
- R1: A cycle with `cpu_wr`=1 and `cpu_addr[15]`=1, at any such address, loads the bank register at that clock edge with `cpu_wdata[1:0] & rom_rdata[1:0]`. The new value appears on `prg_addr[16:15]` from the next cycle on. Data bits 7..2 have no effect.
- R2: A write with `cpu_addr[15]`=0, or any cycle with `cpu_wr`=0, leaves the bank register unchanged.
- R3: `prg_addr` equals {bank, `cpu_addr[14:0]`}. `rom_ce` is 1 exactly when `cpu_addr[15]`=1.
- R4: A synchronous active-high `rst` clears the bank register to 0.
- R5: `ciram_a10` follows `ppu_addr[10]` when `mirror_vert`=1 (vertical mirroring) and `ppu_addr[11]` when `mirror_vert`=0 (horizontal mirroring).
- R6: `chr_addr` equals `ppu_addr[12:0]` with no banking. `chr_ce` is 1 exactly when `ppu_addr[13]`=0.
- R7: Bus conflict: a written 1 bit is lost wherever the ROM byte holds 0. For example, writing 0x03 where the ROM byte ends in binary 00 stores bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_wdata | input | 8 | CPU write data |
| rom_rdata | input | 8 | Byte the ROM drives at the current address |
| mirror_vert | input | 1 | Mirroring strap, 1 = vertical, 0 = horizontal |
| ppu_addr | input | 14 | Picture-bus address |
| rom_ce | output | 1 | Program ROM chip enable |
| prg_addr | output | 17 | Program ROM address |
| chr_addr | output | 13 | Character memory address |
| chr_ce | output | 1 | Character memory enable |
| ciram_a10 | output | 1 | Nametable RAM address bit 10 |

## Verification
The bench's main target is the conflict corner. It writes 0x03 over ROM bytes ending in 00, 01 and 10. A design that stored the raw CPU data would report bank 3 in every case instead of 0, 1 and 2.

It also writes with the upper data bits set and the low bits clear. A design that ANDed the wrong bits or used more than two data bits would then show a nonzero bank.

Writes below 0x8000 and reads inside the ROM window follow a known bank value. A loose address decode would change the bank on one of these accesses.

Both strap settings are driven against addresses that differ in bit 10 and bit 11. Swapping the two mirroring modes therefore gives a wrong `ciram_a10`.

// File: rtl/bnk_pkg.sv
package bnk_pkg;
    localparam int DATA_W   = 8;
    localparam int CPU_AW   = 16;
    localparam int WIN_AW   = 15;
    localparam int BANK_W   = 2;
    localparam int PPU_AW   = 14;
    localparam int CHR_AW   = 13;

    typedef struct packed {
        logic              load;
        logic [BANK_W-1:0] value;
    } bank_upd_t;

    function automatic logic [DATA_W-1:0] conflict_and(
        input logic [DATA_W-1:0] cpu_byte,
        input logic [DATA_W-1:0] rom_byte);
        return cpu_byte & rom_byte;
    endfunction
endpackage

// File: rtl/bnk_decode.sv
module bnk_decode
    import bnk_pkg::*;
#(
    parameter int CPU_W  = CPU_AW,
    parameter int DW     = DATA_W,
    parameter int BW     = BANK_W
) (
    input  logic [CPU_W-1:0] addr,
    input  logic             wr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    rdata,
    output logic             rom_sel,
    output bank_upd_t        upd
);
    localparam int TOP = CPU_W - 1;
    logic [DW-1:0] merged;

    always_comb begin
        rom_sel    = addr[TOP];
        merged     = conflict_and(wdata, rdata);
        upd.load   = wr & addr[TOP];
        upd.value  = merged[BW-1:0];
    end
endmodule

// File: rtl/bnk_latch.sv
module bnk_latch
    import bnk_pkg::*;
#(
    parameter int BW = BANK_W
) (
    input  logic          clk,
    input  logic          rst,
    input  bank_upd_t     upd,
    output logic [BW-1:0] bank
);
    always_ff @(posedge clk) begin
        if (rst)
            bank <= '0;
        else if (upd.load)
            bank <= upd.value;
    end
endmodule

// File: rtl/bnk_ppu_map.sv
module bnk_ppu_map #(
    parameter int PW = 14,
    parameter int CW = 13
) (
    input  logic [PW-1:0] ppu_addr,
    input  logic          mirror_vert,
    output logic [CW-1:0] chr_addr,
    output logic          chr_ce,
    output logic          ciram_a10
);
    always_comb begin
        chr_addr  = ppu_addr[CW-1:0];
        chr_ce    = ~ppu_addr[CW];
        ciram_a10 = mirror_vert ? ppu_addr[10] : ppu_addr[11];
    end
endmodule

// File: rtl/prg_bank_switch.sv
module prg_bank_switch
    import bnk_pkg::*;
#(
    parameter int CPU_W  = CPU_AW,
    parameter int WIN_W  = WIN_AW,
    parameter int BW     = BANK_W,
    parameter int DW     = DATA_W,
    parameter int PW     = PPU_AW,
    parameter int CW     = CHR_AW,
    localparam int PRG_W = WIN_W + BW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CPU_W-1:0] cpu_addr,
    input  logic             cpu_wr,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic [DW-1:0]    rom_rdata,
    input  logic             mirror_vert,
    input  logic [PW-1:0]    ppu_addr,
    output logic             rom_ce,
    output logic [PRG_W-1:0] prg_addr,
    output logic [CW-1:0]    chr_addr,
    output logic             chr_ce,
    output logic             ciram_a10
);
    bank_upd_t     upd;
    logic [BW-1:0] bank;

    bnk_decode #(.CPU_W(CPU_W), .DW(DW), .BW(BW)) u_dec (
        .addr(cpu_addr), .wr(cpu_wr), .wdata(cpu_wdata), .rdata(rom_rdata),
        .rom_sel(rom_ce), .upd(upd)
    );

    bnk_latch #(.BW(BW)) u_lat (
        .clk(clk), .rst(rst), .upd(upd), .bank(bank)
    );

    bnk_ppu_map #(.PW(PW), .CW(CW)) u_ppu (
        .ppu_addr(ppu_addr), .mirror_vert(mirror_vert),
        .chr_addr(chr_addr), .chr_ce(chr_ce), .ciram_a10(ciram_a10)
    );

    assign prg_addr = {bank, cpu_addr[WIN_W-1:0]};
endmodule

// File: rtl/prg_bank_switch_chk.sv
module prg_bank_switch_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic        cpu_wr,
    input logic [7:0]  cpu_wdata,
    input logic [7:0]  rom_rdata,
    input logic        mirror_vert,
    input logic [13:0] ppu_addr,
    input logic        rom_ce,
    input logic [16:0] prg_addr,
    input logic [12:0] chr_addr,
    input logic        chr_ce,
    input logic        ciram_a10
);
    // R1 and R7: ANDed value shows up one cycle after a window write
    a_r1_conflict_load: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15]) |=>
            prg_addr[16:15] == ($past(cpu_wdata[1:0]) & $past(rom_rdata[1:0])));

    // R2: no window write, no bank change
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && cpu_addr[15]) |=> prg_addr[16:15] == $past(prg_addr[16:15]));

    // R3: chip enable and window address
    a_r3_ce: assert property (@(posedge clk) disable iff (rst)
        rom_ce == cpu_addr[15] && prg_addr[14:0] == cpu_addr[14:0]);

    // R4: reset clears bank
    a_r4_reset: assert property (@(posedge clk) rst |=> prg_addr[16:15] == 2'b00);

    // R5: mirroring strap
    a_r5_mirror: assert property (@(posedge clk) disable iff (rst)
        ciram_a10 == (mirror_vert ? ppu_addr[10] : ppu_addr[11]));

    // R6: character pass-through
    a_r6_chr: assert property (@(posedge clk) disable iff (rst)
        chr_addr == ppu_addr[12:0] && chr_ce == !ppu_addr[13]);
endmodule

bind prg_bank_switch prg_bank_switch_chk u_chk (.*);

// File: tb/prg_bank_switch_test.sv
module prg_bank_switch_test;
    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  rom_rdata;
    logic        mirror_vert = 0;
    logic [13:0] ppu_addr = '0;
    logic        rom_ce;
    logic [16:0] prg_addr;
    logic [12:0] chr_addr;
    logic        chr_ce;
    logic        ciram_a10;

    int n_cmp = 0;
    int n_bad = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] model_bank = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    // ROM model: each byte equals the low 8 bits of its address
    assign rom_rdata = prg_addr[7:0];

    prg_bank_switch uut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one access, then push the expected bank
    task automatic access(input logic [15:0] a, input logic wr, input logic [7:0] d, input string req);
        @(negedge clk);
        cpu_addr = a; cpu_wr = wr; cpu_wdata = d;
        @(posedge clk);
        if (wr && a[15]) model_bank = d[1:0] & a[1:0];
        exp_q.push_back(model_bank);
        tag_q.push_back(req);
        @(negedge clk);
        cpu_wr = 0;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, int'(prg_addr[16:15]), int'(e));
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        check("R4 reset bank", int'(prg_addr[16:15]), 0);

        access(16'h8003, 1, 8'h03, "R1 load 3");
        access(16'hC002, 1, 8'h03, "R7 conflict 03 over 10");
        access(16'hFFF1, 1, 8'h03, "R7 conflict 03 over 01");
        access(16'h9000, 1, 8'h03, "R7 conflict 03 over 00");
        access(16'hA003, 1, 8'hFE, "R1 upper bits ignored");
        access(16'hA003, 1, 8'hFC, "R1 upper bits only");
        access(16'hB003, 1, 8'h01, "R1 load 1");
        access(16'h7FFF, 1, 8'h03, "R2 write below window");
        access(16'h0003, 1, 8'h02, "R2 write low");
        access(16'hE003, 0, 8'h02, "R2 read in window");

        @(negedge clk);
        cpu_addr = 16'hD234;
        #1;
        check("R3 rom_ce high", int'(rom_ce), 1);
        check("R3 prg_addr", int'(prg_addr), int'({model_bank, 15'h5234}));
        cpu_addr = 16'h5234;
        #1;
        check("R3 rom_ce low", int'(rom_ce), 0);

        ppu_addr = 14'h2400; mirror_vert = 1; #1;
        check("R5 vertical a10=1", int'(ciram_a10), 1);
        ppu_addr = 14'h2800; #1;
        check("R5 vertical a11 only", int'(ciram_a10), 0);
        mirror_vert = 0; #1;
        check("R5 horizontal a11", int'(ciram_a10), 1);
        ppu_addr = 14'h2400; #1;
        check("R5 horizontal a10 only", int'(ciram_a10), 0);

        ppu_addr = 14'h1ABC; #1;
        check("R6 chr_addr", int'(chr_addr), 'h1ABC);
        check("R6 chr_ce low half", int'(chr_ce), 1);
        ppu_addr = 14'h3ABC; #1;
        check("R6 chr_ce nametable", int'(chr_ce), 0);

        access(16'h8002, 1, 8'h02, "R1 load 2");
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check("R4 reset after load", int'(prg_addr[16:15]), 0);

        repeat (3) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule